// File: doc/BRIEF.md
# Priority-Based Throttle Request Arbiter

The arbiter sits between a set of throttle request sources (two thermal sources of different severity and one overcurrent source in the default build) and the clock-skipping logic that acts on the result. Each source has a programmed numeric priority and its own pair of throttle settings: a CPU skip depth in percent and a 2-bit GPU skip level. The arbiter does not combine requests by OR or maximum. It picks the single requesting source with the largest priority and passes that source's settings through unchanged. It also reports the index of the winning source.

Configuration arrives as plain, flattened register inputs. Source `i` occupies bits `[i*W +: W]` of each flattened bus, where `W` is that field's width. A priority of 0 disables a source. The outputs are registered, so they follow the requests and configuration with one clock of latency.

Top module: `throttle_arbiter`

## Requirements
- R1: While `rstN` is low, and after reset before any request is sampled, `cpuDepthOut` = 0, `gpuLevelOut` = 0, `winnerIdx` = 0 and `throttleActive` = 0.
- R2: When exactly one source with a non-zero priority is requesting, then one clock later `throttleActive` = 1, `winnerIdx` = that source's index, and `cpuDepthOut`/`gpuLevelOut` equal that source's depth and level fields.
- R3: When several enabled sources request together, the outputs take the settings and index of the requesting source with the numerically largest priority. Priority values are unsigned: 1 is the lowest enabled priority, and the default 7-bit field reaches 127.
- R4: When two or more requesting enabled sources share the largest priority, the one with the lowest index wins.
- R5: A source whose priority field is 0 never wins. If only such sources request, the outputs are those of R6.
- R6: When no enabled source is requesting, `throttleActive` = 0, `cpuDepthOut` = 0, `gpuLevelOut` = 0 (level encoding 0 none, 1 low, 2 medium, 3 high) and `winnerIdx` = 0.
- R7: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge. A change in the inputs is not visible before the next edge.
- R8: A change to the winning source's depth, level or priority fields while its request is held takes effect on the outputs at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | NUM_SRC | Request bit per source |
| prioFlat | input | NUM_SRC*PRIO_W | Priority per source, 0 = disabled |
| cpuDepthFlat | input | NUM_SRC*DEPTH_W | CPU skip depth per source, percent |
| gpuLevelFlat | input | NUM_SRC*LEVEL_W | GPU skip level per source |
| cpuDepthOut | output | DEPTH_W | Selected CPU skip depth |
| gpuLevelOut | output | LEVEL_W | Selected GPU skip level |
| throttleActive | output | 1 | An enabled source is driving the outputs |
| winnerIdx | output | $clog2(NUM_SRC) | Index of the winning source |

## Verification
The bench builds the arbiter with its defaults: three sources, 7-bit priority, 7-bit depth and 2-bit level. With these values the full priority span 0 to 127 can be driven, including the legal 1 to 100 range, the disabled value 0 and the largest encodable value. Depths up to 100 fit in the depth field. With three sources, ties between two sources and among all three can be set up, and the winner index reaches its top legal value 2. A pseudo-random sweep draws priorities from a small set so that ties and disabled sources occur often, alongside the directed cases.

// File: rtl/thr_arb_pkg.sv
package thr_arb_pkg;

  localparam int SEL_W   = 4;
  localparam int MAX_SRC = 1 << SEL_W;

  // Strobes from the selection logic to the output datapath
  typedef struct packed {
    logic             grant;  // some enabled source is requesting
    logic [SEL_W-1:0] sel;    // index of the chosen source
  } arb_strobe_t;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_MED  = 2'd2,
    LVL_HIGH = 2'd3
  } gpu_level_e;

endpackage

// File: rtl/thr_arb_ctrl.sv
module thr_arb_ctrl
  import thr_arb_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int PRIO_W  = 7
) (
  input  logic [NUM_SRC-1:0]        reqVec,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  output arb_strobe_t               strobe
);

  logic [PRIO_W-1:0] bestPrio;
  logic [PRIO_W-1:0] candPrio;

  // Strictly-greater compare: equal priority keeps the earlier (lower) index,
  // and a zero priority can never beat the initial zero.
  always_comb begin
    bestPrio   = '0;
    candPrio   = '0;
    strobe.sel = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      candPrio = prioFlat[i*PRIO_W +: PRIO_W];
      if (reqVec[i] && (candPrio > bestPrio)) begin
        bestPrio   = candPrio;
        strobe.sel = SEL_W'(i);
      end
    end
    strobe.grant = (bestPrio != '0);
  end

  // A granted selection always points at a real source
  always_comb begin
    assert_sel_in_range_R3 : assert (!strobe.grant || int'(strobe.sel) < NUM_SRC);
  end

endmodule

// File: rtl/thr_arb_dpath.sv
module thr_arb_dpath
  import thr_arb_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int DEPTH_W = 7,
  parameter int LEVEL_W = 2,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  arb_strobe_t                strobe,
  input  logic [NUM_SRC*DEPTH_W-1:0] cpuDepthFlat,
  input  logic [NUM_SRC*LEVEL_W-1:0] gpuLevelFlat,
  output logic [DEPTH_W-1:0]         cpuDepthOut,
  output logic [LEVEL_W-1:0]         gpuLevelOut,
  output logic                       throttleActive,
  output logic [IDX_W-1:0]           winnerIdx
);

  logic [DEPTH_W-1:0] cpuNext;
  logic [LEVEL_W-1:0] gpuNext;
  logic [IDX_W-1:0]   idxNext;

  always_comb begin
    cpuNext = '0;
    gpuNext = '0;
    idxNext = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strobe.grant && (int'(strobe.sel) == i)) begin
        cpuNext = cpuDepthFlat[i*DEPTH_W +: DEPTH_W];
        gpuNext = gpuLevelFlat[i*LEVEL_W +: LEVEL_W];
        idxNext = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuDepthOut    <= '0;
      gpuLevelOut    <= '0;
      throttleActive <= 1'b0;
      winnerIdx      <= '0;
    end else begin
      cpuDepthOut    <= cpuNext;
      gpuLevelOut    <= gpuNext;
      throttleActive <= strobe.grant;
      winnerIdx      <= idxNext;
    end
  end

  assert_idle_outputs_zero_R6 : assert property (@(posedge clk) disable iff (!rstN)
    !throttleActive |-> (cpuDepthOut == '0 && gpuLevelOut == '0 && winnerIdx == '0));

  assert_winner_in_range_R2 : assert property (@(posedge clk) disable iff (!rstN)
    throttleActive |-> (int'(winnerIdx) < NUM_SRC));

endmodule

// File: rtl/throttle_arbiter.sv
module throttle_arbiter
  import thr_arb_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int PRIO_W  = 7,
  parameter int DEPTH_W = 7,
  parameter int LEVEL_W = 2,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         reqVec,
  input  logic [NUM_SRC*PRIO_W-1:0]  prioFlat,
  input  logic [NUM_SRC*DEPTH_W-1:0] cpuDepthFlat,
  input  logic [NUM_SRC*LEVEL_W-1:0] gpuLevelFlat,
  output logic [DEPTH_W-1:0]         cpuDepthOut,
  output logic [LEVEL_W-1:0]         gpuLevelOut,
  output logic                       throttleActive,
  output logic [IDX_W-1:0]           winnerIdx
);

  arb_strobe_t strobe;

  generate
    if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_count
      initial $error("NUM_SRC out of supported range");
    end
  endgenerate

  thr_arb_ctrl #(
    .NUM_SRC(NUM_SRC),
    .PRIO_W (PRIO_W)
  ) u_ctrl (
    .reqVec  (reqVec),
    .prioFlat(prioFlat),
    .strobe  (strobe)
  );

  thr_arb_dpath #(
    .NUM_SRC(NUM_SRC),
    .DEPTH_W(DEPTH_W),
    .LEVEL_W(LEVEL_W)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .cpuDepthFlat  (cpuDepthFlat),
    .gpuLevelFlat  (gpuLevelFlat),
    .cpuDepthOut   (cpuDepthOut),
    .gpuLevelOut   (gpuLevelOut),
    .throttleActive(throttleActive),
    .winnerIdx     (winnerIdx)
  );

  // Copies of the sampled inputs, used only to relate outputs to the edge they came from
  logic [NUM_SRC-1:0]         reqQ;
  logic [NUM_SRC*PRIO_W-1:0]  prioQ;
  logic [NUM_SRC*DEPTH_W-1:0] cpuQ;
  logic [NUM_SRC*LEVEL_W-1:0] gpuQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ  <= '0;
      prioQ <= '0;
      cpuQ  <= '0;
      gpuQ  <= '0;
    end else begin
      reqQ  <= reqVec;
      prioQ <= prioFlat;
      cpuQ  <= cpuDepthFlat;
      gpuQ  <= gpuLevelFlat;
    end
  end

  assert_winner_requested_R2 : assert property (@(posedge clk) disable iff (!rstN)
    throttleActive |-> reqQ[winnerIdx]);

  assert_winner_enabled_R5 : assert property (@(posedge clk) disable iff (!rstN)
    throttleActive |-> (prioQ[winnerIdx*PRIO_W +: PRIO_W] != '0));

  assert_settings_follow_R8 : assert property (@(posedge clk) disable iff (!rstN)
    throttleActive |-> (cpuDepthOut == cpuQ[winnerIdx*DEPTH_W +: DEPTH_W] &&
                        gpuLevelOut == gpuQ[winnerIdx*LEVEL_W +: LEVEL_W]));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_src_chk
      assert_no_higher_loser_R3 : assert property (@(posedge clk) disable iff (!rstN)
        (throttleActive && reqQ[gi] && int'(winnerIdx) != gi) |->
          (prioQ[gi*PRIO_W +: PRIO_W] <= prioQ[winnerIdx*PRIO_W +: PRIO_W]));

      assert_tie_low_index_R4 : assert property (@(posedge clk) disable iff (!rstN)
        (throttleActive && reqQ[gi] && gi < int'(winnerIdx)) |->
          (prioQ[gi*PRIO_W +: PRIO_W] < prioQ[winnerIdx*PRIO_W +: PRIO_W]));

      assert_idle_means_none_R6 : assert property (@(posedge clk) disable iff (!rstN)
        (!throttleActive && reqQ[gi]) |-> (prioQ[gi*PRIO_W +: PRIO_W] == '0));
    end
  endgenerate

endmodule

// File: tb/test_throttle_arbiter.sv
module test_throttle_arbiter;

  localparam int N  = 3;
  localparam int PW = 7;
  localparam int DW = 7;
  localparam int LW = 2;
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [N-1:0]    reqVec = '0;
  logic [N*PW-1:0] prioFlat = '0;
  logic [N*DW-1:0] cpuDepthFlat = '0;
  logic [N*LW-1:0] gpuLevelFlat = '0;
  logic [DW-1:0]   cpuDepthOut;
  logic [LW-1:0]   gpuLevelOut;
  logic            throttleActive;
  logic [IW-1:0]   winnerIdx;

  always #4 clk = ~clk;

  throttle_arbiter i_throttle_arbiter (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .prioFlat(prioFlat),
    .cpuDepthFlat(cpuDepthFlat), .gpuLevelFlat(gpuLevelFlat),
    .cpuDepthOut(cpuDepthOut), .gpuLevelOut(gpuLevelOut),
    .throttleActive(throttleActive), .winnerIdx(winnerIdx)
  );

  int vecs = 0;
  int bad = 0;
  bit finished = 0;

  int prio[N];
  int cpu[N];
  int gpu[N];
  int expCpu = 0, expGpu = 0, expAct = 0, expIdx = 0;

  task automatic cmp(input string tag, input string name, input int act, input int exp);
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, name, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    vecs++;
    cmp(tag, "throttleActive", int'(throttleActive), expAct);
    cmp(tag, "cpuDepthOut", int'(cpuDepthOut), expCpu);
    cmp(tag, "gpuLevelOut", int'(gpuLevelOut), expGpu);
    cmp(tag, "winnerIdx", int'(winnerIdx), expIdx);
  endtask

  task automatic setSrc(input int i, input int p, input int c, input int g);
    prio[i] = p; cpu[i] = c; gpu[i] = g;
  endtask

  // Behavioural reference: largest priority among requesters, first one kept on ties
  task automatic model(input logic [N-1:0] r);
    int best;
    best = 0; expIdx = 0;
    for (int i = 0; i < N; i++)
      if (r[i] && prio[i] > best) begin best = prio[i]; expIdx = i; end
    expAct = (best > 0) ? 1 : 0;
    if (!expAct) expIdx = 0;
    expCpu = expAct ? cpu[expIdx] : 0;
    expGpu = expAct ? gpu[expIdx] : 0;
  endtask

  task automatic step(input logic [N-1:0] r, input string tag);
    @(negedge clk);
    reqVec = r;
    for (int i = 0; i < N; i++) begin
      prioFlat[i*PW +: PW]     = PW'(prio[i]);
      cpuDepthFlat[i*DW +: DW] = DW'(cpu[i]);
      gpuLevelFlat[i*LW +: LW] = LW'(gpu[i]);
    end
    #1;
    checkAll("R7");          // outputs still hold the previous result
    model(r);
    @(posedge clk);
    #2;
    checkAll(tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) setSrc(i, 0, 0, 0);
    // R1: reset holds outputs at zero even with a request present
    setSrc(0, 80, 50, 1);
    reqVec = 3'b001;
    prioFlat[0 +: PW] = 7'd80;
    cpuDepthFlat[0 +: DW] = 7'd50;
    gpuLevelFlat[0 +: LW] = 2'd1;
    repeat (3) @(posedge clk);
    #2;
    expAct = 0; expCpu = 0; expGpu = 0; expIdx = 0;
    checkAll("R1");
    @(negedge clk);
    reqVec = '0;
    rstN = 1'b1;
    #1;
    checkAll("R1");

    // Sources: 0 light, 1 heavy, 2 overcurrent
    setSrc(0, 80, 50, 1);
    setSrc(1, 100, 85, 3);
    setSrc(2, 50, 75, 2);
    step(3'b000, "R6");
    step(3'b001, "R2");
    step(3'b010, "R2");
    step(3'b100, "R2");
    step(3'b011, "R3");
    step(3'b101, "R3");
    step(3'b111, "R3");
    step(3'b000, "R6");
    // R8: reprogram the holder's settings while it keeps requesting
    step(3'b010, "R8");
    setSrc(1, 100, 33, 1);
    step(3'b010, "R8");
    setSrc(1, 10, 33, 1);
    step(3'b011, "R8");
    // R4: ties
    setSrc(0, 60, 20, 1); setSrc(1, 60, 40, 2); setSrc(2, 60, 60, 3);
    step(3'b110, "R4");
    step(3'b111, "R4");
    step(3'b101, "R4");
    // R5: disabled sources
    setSrc(0, 0, 90, 3); setSrc(1, 0, 90, 3); setSrc(2, 1, 5, 1);
    step(3'b001, "R5");
    step(3'b011, "R5");
    step(3'b111, "R5");
    setSrc(2, 0, 5, 1);
    step(3'b111, "R5");
    // R3: top of the encodable range
    setSrc(0, 127, 100, 3); setSrc(1, 126, 1, 1); setSrc(2, 100, 2, 2);
    step(3'b111, "R3");
    step(3'b110, "R3");

    // Pseudo-random sweep with a narrow priority set to force ties and disables
    begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
        for (int i = 0; i < N; i++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          setSrc(i, int'(lfsr[2:0]) * 18, int'(lfsr[9:3]) % 101, int'(lfsr[11:10]));
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[2:0], "R3");
      end
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

endmodule